// File: doc/BRIEF.md
# ADC Autoscan Sequencer

This block drives a successive-approximation converter across a set of up to eight analog channels. Software picks the channels with an 8-bit scan mask. The sequencer then visits each selected channel in ascending order. For each one it produces a sample phase, ten bit-decision strobes and a store strobe that carries the channel index and the 10-bit code it assembled from the comparator input. The analog comparator, the DAC ladder and the result storage are outside the block.

A scan loop starts in one of two ways: a software start pulse, or an edge on an external start pin. That pin is synchronized inside the block, and its rising and falling edges can be enabled separately. All timing is counted in machine cycles, which arrive as one-clock enable pulses and are divided by a prescaler of 2, 4, 6 or 8.

When a loop ends, a sticky interrupt flag is raised. In one-shot mode the sequencer then stops; in continuous mode it begins the next loop. A start that arrives while the flag is still set is held back until software clears the flag. A power-down input aborts any work in progress.

Top module: `adc_scan_seq`

## Requirements
- R1: Bit i of `scan_mask` set includes channel i in the loop and clear skips it. A start request made while `scan_mask` is all zero has no effect: `busy_o` stays 0 and no store occurs.
- R2: A loop begins at the lowest set mask bit. After each store it moves to the next higher set bit, and the index is reported on `chan_sel` and `store_chan`.
- R3: The mask is captured when a loop begins, so a change made mid-loop affects only the next loop.
- R4: One conversion runs as follows: `sample_o` stays high for m machine cycles, ten bit periods of m/2 machine cycles each follow, and then one machine cycle for the store. From the fall of `sample_o` to the `store_o` pulse is (5m+1) machine cycles. Adjacent stores within or across loops are 7m machine cycles apart.
- R5: `presc_sel` selects m as follows: 00 gives 2, 01 gives 4, 10 gives 6 and 11 gives 8.
- R6: `irq_o` rises in the same cycle as the `store_o` pulse of the last channel of a loop and not before. Hardware never clears it; only `irq_clr` or reset does.
- R7: In continuous mode (`cont_mode`=1) `busy_o` stays 1 and the loop restarts from the lowest set bit of the current mask. In one-shot mode `busy_o` returns to 0 with the last store.
- R8: A start request that arrives while `irq_o`=1 is latched. `busy_o` reads 0 while the request waits, and the loop begins once the flag is cleared.
- R9: `ext_start` passes through two synchronizing flops. A rising edge starts a loop only when `ext_rise_en`=1, and a falling edge only when `ext_fall_en`=1.
- R10: While `pwr_down`=1 the sequencer aborts, `busy_o` reads 0, no store occurs and held requests are dropped. `irq_o` keeps its value.
- R11: Each bit decision samples `cmp_in` MSB first into the code. `store_data` equals the ten decisions of that conversion, with the first decision in bit 9.
- R12: `sample_o`, `bit_stb` and `store_o` are never high together. Each conversion gives exactly ten `bit_stb` pulses before its `store_o` pulse, and `bit_stb` and `store_o` follow a machine-cycle enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_en | input | 1 | One-clock machine-cycle enable pulse |
| scan_mask | input | 8 | Channel inclusion mask |
| sw_start | input | 1 | Software start pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| ext_rise_en | input | 1 | Enable start on a rising edge of the pin |
| ext_fall_en | input | 1 | Enable start on a falling edge of the pin |
| cont_mode | input | 1 | 1 = continuous loops, 0 = one loop |
| presc_sel | input | 2 | Prescaler divisor select |
| pwr_down | input | 1 | Idle/power-down abort |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| cmp_in | input | 1 | Comparator decision bit |
| busy_o | output | 1 | Effective busy/start status |
| irq_o | output | 1 | Sticky loop-complete flag |
| chan_sel | output | 3 | Channel being converted |
| sample_o | output | 1 | Sample phase active |
| bit_stb | output | 1 | One bit decision just taken |
| store_o | output | 1 | Result-store strobe |
| store_chan | output | 3 | Channel of the stored result |
| store_data | output | 10 | Stored 10-bit code |

## Verification
Several properties are checked by the assertions on every cycle:
- a loop never launches from an empty mask or while the flag is set;
- the flag falls only after a clear request and rises only with a store;
- a power-down cycle leaves no busy state or strobe behind;
- the three strobes stay exclusive and follow a machine-cycle pulse.

Other behaviour can only be shown by the directed scenarios. These cover the ascending channel order, the codes assembled from the comparator, the exact machine-cycle spacing at each prescaler setting, mask changes during a continuous loop, the held start and its release, and the edge selection on the external pin.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SAMPLE,
      PH_BITS,
      PH_STORE,
      PH_INIT
   } scan_phase_e;
endpackage

// File: rtl/adcs_edge_in.sv
module adcs_edge_in #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_en,
   input  logic fall_en,
   output logic edge_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("adcs_edge_in: SYNC_STAGES must be at least 2");
   end

   // stage SYNC_STAGES holds the previous synchronized level
   logic [SYNC_STAGES:0] sh;

   for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= pin;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[s] <= 1'b0;
            else        sh[s] <= sh[s-1];
      end
   end

   logic now_lvl, old_lvl;
   assign now_lvl = sh[SYNC_STAGES-1];
   assign old_lvl = sh[SYNC_STAGES];
   assign edge_o  = (rise_en & now_lvl & ~old_lvl) | (fall_en & ~now_lvl & old_lvl);
endmodule

// File: rtl/adcs_low_pick.sv
module adcs_low_pick #(
   parameter int NCH = 8,
   localparam int CW = $clog2(NCH)
) (
   input  logic [NCH-1:0] mask,
   output logic           found,
   output logic [CW-1:0]  idx
);
   always_comb begin
      found = |mask;
      idx   = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask[i]) idx = CW'(i);
      end
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adcs_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int RES_BITS    = 10,
   parameter int PRESC_W     = 2,
   parameter int SYNC_STAGES = 2,
   localparam int CW         = $clog2(NCH),
   localparam int MAXDIV     = 2 * (2 ** PRESC_W),
   localparam int CNT_W      = $clog2(MAXDIV + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mc_en,
   input  logic [NCH-1:0]      scan_mask,
   input  logic                sw_start,
   input  logic                ext_start,
   input  logic                ext_rise_en,
   input  logic                ext_fall_en,
   input  logic                cont_mode,
   input  logic [PRESC_W-1:0]  presc_sel,
   input  logic                pwr_down,
   input  logic                irq_clr,
   input  logic                cmp_in,
   output logic                busy_o,
   output logic                irq_o,
   output logic [CW-1:0]       chan_sel,
   output logic                sample_o,
   output logic                bit_stb,
   output logic                store_o,
   output logic [CW-1:0]       store_chan,
   output logic [RES_BITS-1:0] store_data
);
   if (NCH < 2 || RES_BITS < 2 || PRESC_W < 1) begin : g_bad_cfg
      $error("adc_scan_seq: NCH and RES_BITS must be >= 2, PRESC_W >= 1");
   end

   localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

   scan_phase_e         phase;
   logic [CNT_W-1:0]    tick;
   logic [CNT_W-1:0]    m_div, half_div;
   logic [RES_BITS-1:0] sar, bit_sel;
   logic [CW-1:0]       cur;
   logic [NCH-1:0]      loop_mask, above_cur;
   logic                run, pend, irq;
   logic                ext_edge, req, launch, mask_nz;
   logic                first_found, nxt_found;
   logic [CW-1:0]       first_idx, nxt_idx;

   // m = 2 * (sel + 1), so a bit period of m/2 is never zero
   assign m_div    = (CNT_W'(presc_sel) + CNT_W'(1)) << 1;
   assign half_div = m_div >> 1;

   adcs_edge_in #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_start),
      .rise_en(ext_rise_en), .fall_en(ext_fall_en), .edge_o(ext_edge)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_above
      assign above_cur[g] = (CW'(g) > cur);
   end

   adcs_low_pick #(.NCH(NCH)) i_pick_first (
      .mask(scan_mask), .found(first_found), .idx(first_idx)
   );
   adcs_low_pick #(.NCH(NCH)) i_pick_next (
      .mask(loop_mask & above_cur), .found(nxt_found), .idx(nxt_idx)
   );

   assign mask_nz = first_found;
   assign req     = sw_start | ext_edge;
   assign launch  = pend & ~irq & ~run & ~pwr_down & mask_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         tick       <= '0;
         sar        <= '0;
         bit_sel    <= '0;
         cur        <= '0;
         loop_mask  <= '0;
         run        <= 1'b0;
         pend       <= 1'b0;
         irq        <= 1'b0;
         bit_stb    <= 1'b0;
         store_o    <= 1'b0;
         store_chan <= '0;
         store_data <= '0;
      end else begin
         bit_stb <= 1'b0;
         store_o <= 1'b0;
         if (irq_clr)         irq  <= 1'b0;
         if (req && mask_nz)  pend <= 1'b1;
         if (pwr_down) begin
            phase <= PH_IDLE;
            run   <= 1'b0;
            pend  <= 1'b0;
         end else if (launch) begin
            run       <= 1'b1;
            pend      <= 1'b0;
            phase     <= PH_SAMPLE;
            tick      <= '0;
            sar       <= '0;
            bit_sel   <= MSB_ONE;
            cur       <= first_idx;
            loop_mask <= scan_mask;
         end else if (run && mc_en) begin
            unique case (phase)
               PH_SAMPLE: begin
                  if (tick == m_div - CNT_W'(1)) begin
                     phase <= PH_BITS;
                     tick  <= '0;
                  end else tick <= tick + CNT_W'(1);
               end
               PH_BITS: begin
                  if (tick == half_div - CNT_W'(1)) begin
                     tick    <= '0;
                     bit_stb <= 1'b1;
                     if (cmp_in) sar <= sar | bit_sel;
                     bit_sel <= bit_sel >> 1;
                     if (bit_sel[0]) phase <= PH_STORE;
                  end else tick <= tick + CNT_W'(1);
               end
               PH_STORE: begin
                  store_o    <= 1'b1;
                  store_chan <= cur;
                  store_data <= sar;
                  tick       <= '0;
                  if (nxt_found) begin
                     cur   <= nxt_idx;
                     phase <= PH_INIT;
                  end else begin
                     irq <= 1'b1;
                     if (cont_mode && first_found) begin
                        loop_mask <= scan_mask;
                        cur       <= first_idx;
                        phase     <= PH_INIT;
                     end else begin
                        run   <= 1'b0;
                        phase <= PH_IDLE;
                     end
                  end
               end
               PH_INIT: begin
                  if (tick == m_div - CNT_W'(2)) begin
                     phase   <= PH_SAMPLE;
                     tick    <= '0;
                     sar     <= '0;
                     bit_sel <= MSB_ONE;
                  end else tick <= tick + CNT_W'(1);
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assign busy_o   = run;
   assign irq_o    = irq;
   assign chan_sel = cur;
   assign sample_o = run && (phase == PH_SAMPLE);
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           mc_en,
   input logic [NCH-1:0] scan_mask,
   input logic           irq_clr,
   input logic           pwr_down,
   input logic           busy_o,
   input logic           irq_o,
   input logic           sample_o,
   input logic           bit_stb,
   input logic           store_o
);
   a_r1_launch_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(scan_mask) != '0));

   a_r8_no_launch_while_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(irq_o));

   a_r6_irq_cleared_by_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(irq_clr));

   a_r6_irq_sets_with_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> store_o);

   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (!busy_o && !store_o && !sample_o));

   a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sample_o, bit_stb, store_o}));

   a_r12_bit_on_mc: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> $past(mc_en));

   a_r12_store_on_mc: assert property (@(posedge clk) disable iff (!rst_n)
      store_o |-> ($past(mc_en) && $past(busy_o)));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) i_chk (
   .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .scan_mask(scan_mask),
   .irq_clr(irq_clr), .pwr_down(pwr_down), .busy_o(busy_o), .irq_o(irq_o),
   .sample_o(sample_o), .bit_stb(bit_stb), .store_o(store_o)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
   localparam int MCP = 3;   // clocks per machine cycle

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_en = 1'b0;
   logic [7:0] scan_mask = '0;
   logic       sw_start = 1'b0, ext_start = 1'b0;
   logic       ext_rise_en = 1'b0, ext_fall_en = 1'b0;
   logic       cont_mode = 1'b0;
   logic [1:0] presc_sel = '0;
   logic       pwr_down = 1'b0, irq_clr = 1'b0, cmp_in = 1'b0;
   logic       busy_o, irq_o, sample_o, bit_stb, store_o;
   logic [2:0] chan_sel, store_chan;
   logic [9:0] store_data;

   adc_scan_seq i_adc_scan_seq (.*);

   always #10 clk = ~clk;

   int nchk = 0, nfail = 0, cyc = 0;
   int n_st = 0, k = 0, sf_t = 0;
   int st_ch[32], st_dat[32], st_t[32], st_sf[32], st_irq[32], st_k[32];

   function automatic logic [9:0] code_of(input int ch);
      return 10'(10'h2A5 ^ (ch * 73));
   endfunction

   // machine-cycle pulse generator
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div   = (div == MCP - 1) ? 0 : div + 1;
         mc_en = (div == 0);
      end
   end

   // comparator model and store recorder
   initial begin
      logic       prev_s = 1'b0;
      logic [9:0] cv;
      forever begin
         @(negedge clk);
         cyc++;
         if (prev_s && !sample_o) sf_t = cyc;
         prev_s = sample_o;
         if (sample_o) k = 0;
         if (bit_stb) k++;
         if (store_o && n_st < 32) begin
            st_ch[n_st]  = int'(store_chan);
            st_dat[n_st] = int'(store_data);
            st_t[n_st]   = cyc;
            st_sf[n_st]  = sf_t;
            st_irq[n_st] = int'(irq_o);
            st_k[n_st]   = k;
            n_st++;
         end
         cv     = code_of(int'(chan_sel));
         cmp_in = (k < 10) ? cv[9-k] : 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
   endtask

   task automatic wait_st(input int n);
      for (int i = 0; i < 5000 && n_st < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(busy_o == 1'b0, "R7", "busy after reset", int'(busy_o), 0);
      chk(irq_o == 1'b0, "R6", "irq after reset", int'(irq_o), 0);
      chk(store_o == 1'b0, "R12", "store after reset", int'(store_o), 0);
   endtask

   task automatic t_zero_mask();
      scan_mask = 8'h00; n_st = 0;
      pulse_sw();
      ticks(60);
      chk(busy_o == 1'b0, "R1", "busy with empty mask", int'(busy_o), 0);
      chk(n_st == 0, "R1", "stores with empty mask", n_st, 0);
   endtask

   task automatic t_oneshot_m2();
      presc_sel = 2'b00; cont_mode = 1'b0; scan_mask = 8'h24; n_st = 0;
      pulse_sw();
      ticks(4);
      wait_idle();
      chk(n_st == 2, "R1", "store count mask 24", n_st, 2);
      chk(st_ch[0] == 2, "R2", "first channel", st_ch[0], 2);
      chk(st_ch[1] == 5, "R2", "second channel", st_ch[1], 5);
      chk(st_dat[0] == int'(code_of(2)), "R11", "code ch2", st_dat[0], int'(code_of(2)));
      chk(st_dat[1] == int'(code_of(5)), "R11", "code ch5", st_dat[1], int'(code_of(5)));
      chk(st_k[0] == 10, "R12", "bit strobes per conversion", st_k[0], 10);
      chk(st_irq[0] == 0, "R6", "irq before last store", st_irq[0], 0);
      chk(st_irq[1] == 1, "R6", "irq with last store", st_irq[1], 1);
      chk(st_t[1] - st_t[0] == 7 * 2 * MCP, "R4", "store spacing m=2",
          st_t[1] - st_t[0], 7 * 2 * MCP);
      chk(st_t[0] - st_sf[0] == (5 * 2 + 1) * MCP, "R5", "sample end to store m=2",
          st_t[0] - st_sf[0], (5 * 2 + 1) * MCP);
      ticks(100);
      chk(irq_o == 1'b1, "R6", "irq sticky", int'(irq_o), 1);
      chk(busy_o == 1'b0, "R7", "one-shot busy cleared", int'(busy_o), 0);
   endtask

   task automatic t_held_start();
      presc_sel = 2'b11; scan_mask = 8'h01; n_st = 0;
      pulse_sw();
      ticks(80);
      chk(busy_o == 1'b0, "R8", "busy while start held", int'(busy_o), 0);
      chk(n_st == 0, "R8", "stores while start held", n_st, 0);
      pulse_clr();
      ticks(3);
      chk(busy_o == 1'b1, "R8", "held start released", int'(busy_o), 1);
      wait_idle();
      chk(n_st == 1 && st_ch[0] == 0, "R8", "held loop channel", st_ch[0], 0);
      chk(st_t[0] - st_sf[0] == (5 * 8 + 1) * MCP, "R5", "sample end to store m=8",
          st_t[0] - st_sf[0], (5 * 8 + 1) * MCP);
      chk(st_dat[0] == int'(code_of(0)), "R11", "code ch0", st_dat[0], int'(code_of(0)));
      pulse_clr();
   endtask

   task automatic t_cont_mask();
      int n;
      presc_sel = 2'b01; scan_mask = 8'h03; cont_mode = 1'b1; n_st = 0;
      pulse_sw();
      wait_st(1);
      scan_mask = 8'h80;
      wait_st(4);
      chk(st_ch[1] == 1, "R3", "old mask finishes loop", st_ch[1], 1);
      chk(st_ch[2] == 7 && st_ch[3] == 7, "R3", "new mask next loop", st_ch[2], 7);
      chk(st_t[1] - st_t[0] == 7 * 4 * MCP, "R4", "store spacing m=4",
          st_t[1] - st_t[0], 7 * 4 * MCP);
      chk(st_t[2] - st_t[1] == 7 * 4 * MCP, "R4", "spacing across loops",
          st_t[2] - st_t[1], 7 * 4 * MCP);
      chk(st_irq[0] == 0 && st_irq[1] == 1, "R6", "irq at loop end", st_irq[1], 1);
      chk(busy_o == 1'b1, "R7", "continuous keeps busy", int'(busy_o), 1);
      @(negedge clk); pwr_down = 1'b1;
      ticks(2);
      chk(busy_o == 1'b0, "R10", "busy after abort", int'(busy_o), 0);
      chk(irq_o == 1'b1, "R10", "irq kept on abort", int'(irq_o), 1);
      n = n_st;
      ticks(400);
      chk(n_st == n, "R10", "no store while powered down", n_st, n);
      pwr_down = 1'b0;
      ticks(50);
      chk(busy_o == 1'b0, "R10", "no resume after abort", int'(busy_o), 0);
      cont_mode = 1'b0;
      pulse_clr();
   endtask

   task automatic t_ext();
      presc_sel = 2'b00; scan_mask = 8'h10; n_st = 0;
      ext_rise_en = 1'b1; ext_fall_en = 1'b0;
      @(negedge clk); ext_start = 1'b1;
      ticks(8);
      chk(busy_o == 1'b1, "R9", "rising edge starts", int'(busy_o), 1);
      wait_idle();
      chk(n_st == 1 && st_ch[0] == 4, "R9", "ext loop channel", st_ch[0], 4);
      pulse_clr();
      ext_start = 1'b0;
      ticks(20);
      chk(busy_o == 1'b0 && n_st == 1, "R9", "falling edge ignored", int'(busy_o), 0);
      ext_rise_en = 1'b0; ext_fall_en = 1'b1;
      ext_start = 1'b1;
      ticks(20);
      chk(busy_o == 1'b0, "R9", "rising edge ignored", int'(busy_o), 0);
      ext_start = 1'b0;
      ticks(8);
      chk(busy_o == 1'b1, "R9", "falling edge starts", int'(busy_o), 1);
      wait_idle();
      pulse_clr();
      ext_fall_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      ticks(5);
      rst_n = 1'b1;
      ticks(2);
      t_reset();
      t_zero_mask();
      t_oneshot_m2();
      t_held_start();
      t_cont_mask();
      t_ext();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule